// File: doc/BRIEF.md
# Memory type range resolver

The resolver turns a physical page address into a cacheability type code. It draws on three sources of configuration, all loaded through one write port. The first is an 88-entry table that covers the first megabyte at three granularities. The second is a parameterised set of base/mask range pairs. The third is a control word that carries the enables and a fallback type. A fourth register gives the upper bound of a high-memory window in which everything resolves to write-back.

A lookup is a single-cycle request carrying an address. The type code and a valid strobe appear on the next clock edge. The result stays on the output until the next request. Overlapping variable ranges are merged in combinational logic ahead of the output register. The merge does not depend on the order of the ranges.

Type codes: uncacheable 0x00, write-combining 0x01, write-through 0x04, write-protect 0x05, write-back 0x06, invalid 0xFF. The address width must be at least 33 bits, so that the 4 GiB boundary exists.

Top module: `mem_type_resolver`

## Requirements
- R1: When `lk_req` is high at a clock edge, `res_valid` is high for exactly the following cycle. `res_type` changes only after a request and otherwise holds its value.
- R2: While the global enable (control bit 11) is clear, every lookup returns 0xFF.
- R3: When the fixed path is taken, an address below 0x80000 returns fixed entry number addr[18:16].
- R4: When the fixed path is taken, an address in 0x80000–0xBFFFF returns fixed entry 8 + ((addr − 0x80000) >> 14).
- R5: When the fixed path is taken, an address in 0xC0000–0xFFFFF returns fixed entry 24 + ((addr − 0xC0000) >> 12).
- R6: The fixed path is taken only for addresses below 1 MiB with the fixed enable (control bit 10) set and fixed support built in. When it is taken, it overrides every variable range.
- R7: A variable range takes part only if bit 11 of its mask is set. It matches when (addr XOR base) AND mask is zero above bit 11. Its type is base[7:0].
- R8: Several matching ranges merge as follows. Uncacheable beats everything. Write-back together with write-through gives write-through. Any other pair of different types gives uncacheable. Equal types stay unchanged.
- R9: With no fixed hit, no variable match and no high-memory override, the result is control bits [7:0].
- R10: A nonzero high-memory bound makes addresses at or above 4 GiB and below the bound resolve to write-back, overriding the variable ranges. The bound is stored with bits below 23 cleared.
- R11: After reset, `res_valid` is low and all configuration is zero, so a lookup returns 0xFF.
- R12: Configuration write: `cfg_we` with `cfg_sel` = 0 writes fixed entry `cfg_idx` (0–87) from data[7:0]. Select 1 writes base `cfg_idx` and select 2 writes mask `cfg_idx`. Select 3 writes the control word from data[11:0], and select 4 writes the high-memory bound. A write takes effect for lookups from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Target: 0 fixed, 1 base, 2 mask, 3 control, 4 high bound |
| cfg_idx | input | 7 | Fixed entry or range number |
| cfg_wdata | input | PA_W | Write data |
| lk_req | input | 1 | Lookup request |
| lk_addr | input | PA_W | Physical address to resolve |
| res_valid | output | 1 | Result strobe, one cycle after the request |
| res_type | output | 8 | Resolved type code |

## Verification
A corrupted table entry or range register appears on `res_type` one cycle after the first lookup that selects it. For that reason the bench fills each fixed entry with its own index, so a wrong index computation shows up directly as a wrong number. The range set is built so that each merge rule decides at least one probed address. The probes also include addresses just inside and just outside the high-memory bound, placed on either side of the 8 MiB masking. A fault in the enable decoding turns a whole class of addresses into 0xFF or into the default type, and this is visible on the very next strobe.

// File: rtl/mem_type_resolver.sv
module mem_type_resolver #(
  parameter int NUM_VAR   = 8,
  parameter int PA_W      = 36,
  parameter bit HAS_FIXED = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [2:0]      cfg_sel,
  input  logic [6:0]      cfg_idx,
  input  logic [PA_W-1:0] cfg_wdata,
  input  logic            lk_req,
  input  logic [PA_W-1:0] lk_addr,
  output logic            res_valid,
  output logic [7:0]      res_type
);
  localparam int FIX_N = 88;
  localparam logic [7:0] T_UC  = 8'h00;
  localparam logic [7:0] T_WT  = 8'h04;
  localparam logic [7:0] T_WB  = 8'h06;
  localparam logic [7:0] T_INV = 8'hFF;
  localparam logic [PA_W-1:0] PG_KEEP   = {PA_W{1'b1}} << 12;
  localparam logic [PA_W-1:0] BOUND_KEEP = {PA_W{1'b1}} << 23;

  logic [7:0]      fix_q [FIX_N];
  logic [PA_W-1:0] base_q [NUM_VAR];
  logic [PA_W-1:0] mask_q [NUM_VAR];
  logic [7:0]      def_q;
  logic            en_glob, en_fix;
  logic [PA_W-1:0] bound_q;

  wire wr_fix = cfg_we && cfg_sel == 3'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < FIX_N; i++) fix_q[i] <= '0;
      def_q   <= '0;
      en_glob <= 1'b0;
      en_fix  <= 1'b0;
      bound_q <= '0;
    end else if (cfg_we) begin
      if (wr_fix && int'(cfg_idx) < FIX_N) fix_q[cfg_idx] <= cfg_wdata[7:0];
      if (cfg_sel == 3'd3) begin
        def_q   <= cfg_wdata[7:0];
        en_fix  <= cfg_wdata[10];
        en_glob <= cfg_wdata[11];
      end
      if (cfg_sel == 3'd4) bound_q <= cfg_wdata & BOUND_KEEP;
    end
  end

  logic [NUM_VAR-1:0] hit;

  for (genvar g = 0; g < NUM_VAR; g++) begin : g_rng
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q[g] <= '0;
        mask_q[g] <= '0;
      end else if (cfg_we && int'(cfg_idx) == g) begin
        if (cfg_sel == 3'd1) base_q[g] <= cfg_wdata;
        if (cfg_sel == 3'd2) mask_q[g] <= cfg_wdata;
      end
    end
    assign hit[g] = mask_q[g][11] && ~|((lk_addr ^ base_q[g]) & mask_q[g] & PG_KEEP);
  end

  function automatic logic [7:0] merge(input logic [7:0] a, input logic [7:0] b);
    if (a == T_UC || b == T_UC) return T_UC;
    if (a == b) return a;
    if ((a == T_WB && b == T_WT) || (a == T_WT && b == T_WB)) return T_WT;
    return T_UC;
  endfunction

  logic [7:0] var_t;
  always_comb begin
    var_t = T_INV;
    for (int i = 0; i < NUM_VAR; i++)
      if (hit[i]) var_t = (var_t == T_INV) ? base_q[i][7:0] : merge(var_t, base_q[i][7:0]);
  end

  logic [6:0] fix_idx;
  always_comb begin
    if (!lk_addr[19])      fix_idx = {4'd0, lk_addr[18:16]};
    else if (!lk_addr[18]) fix_idx = 7'd8 + {3'd0, lk_addr[17:14]};
    else                   fix_idx = 7'd24 + {1'b0, lk_addr[17:12]};
  end

  wire low_mb  = ~|lk_addr[PA_W-1:20];
  wire hi_mem  = |lk_addr[PA_W-1:32];
  wire in_high = (bound_q != '0) && hi_mem && (lk_addr < bound_q);

  logic [7:0] nxt;
  always_comb begin
    if (!en_glob)                        nxt = T_INV;
    else if (HAS_FIXED && en_fix && low_mb) nxt = fix_q[fix_idx];
    else if (in_high)                    nxt = T_WB;
    else if (var_t != T_INV)             nxt = var_t;
    else                                 nxt = def_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_type  <= T_INV;
    end else begin
      res_valid <= lk_req;
      if (lk_req) res_type <= nxt;
    end
  end

  a_r1_strobe_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> res_valid);
  a_r1_no_strobe_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> !res_valid);
  a_r1_hold_type: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> $stable(res_type));
  a_r2_disabled_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req && !en_glob |=> res_type == T_INV);
  a_r10_high_window_wb: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req && en_glob && bound_q != '0 && hi_mem && lk_addr < bound_q |=> res_type == T_WB);
endmodule

// File: tb/test_mem_type_resolver.sv
`timescale 1ns/1ps
module test_mem_type_resolver;
  localparam int PA_W = 36;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_sel = '0;
  logic [6:0] cfg_idx = '0;
  logic [PA_W-1:0] cfg_wdata = '0;
  logic lk_req = 1'b0;
  logic [PA_W-1:0] lk_addr = '0;
  logic res_valid;
  logic [7:0] res_type;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mem_type_resolver #(.NUM_VAR(8), .PA_W(PA_W), .HAS_FIXED(1'b1)) i_mem_type_resolver (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .lk_req(lk_req), .lk_addr(lk_addr),
    .res_valid(res_valid), .res_type(res_type));

  // {requirement, address, expected type}
  localparam int NV = 23;
  localparam logic [51:0] VEC [NV] = '{
    {8'd3,  36'h0_0000_0000, 8'd0},   // R3
    {8'd3,  36'h0_0005_0000, 8'd5},   // R3
    {8'd3,  36'h0_0007_FFFF, 8'd7},   // R3
    {8'd4,  36'h0_0008_0000, 8'd8},   // R4
    {8'd4,  36'h0_0009_C000, 8'd15},  // R4
    {8'd4,  36'h0_000B_FFFF, 8'd23},  // R4
    {8'd5,  36'h0_000C_0000, 8'd24},  // R5
    {8'd5,  36'h0_000E_3000, 8'd59},  // R5
    {8'd5,  36'h0_000F_FFFF, 8'd87},  // R5
    {8'd6,  36'h0_0010_0000, 8'd6},   // R6 first address above 1 MiB
    {8'd7,  36'h0_1000_0000, 8'd6},   // R7 single match
    {8'd8,  36'h0_2000_0000, 8'd6},   // R8 equal types
    {8'd8,  36'h0_2800_0000, 8'd4},   // R8 WB with WT
    {8'd8,  36'h0_4000_0000, 8'd0},   // R8 UC wins
    {8'd7,  36'h0_4000_0FFF, 8'd0},   // R7 low bits ignored
    {8'd7,  36'h0_4000_1000, 8'd6},   // R7 just past 4 KB range
    {8'd8,  36'h0_8000_0000, 8'd0},   // R8 WP with WC
    {8'd7,  36'h0_8010_0000, 8'd5},   // R7
    {8'd7,  36'h0_C000_0000, 8'd1},   // R7 disabled range falls to default
    {8'd10, 36'h1_0000_0000, 8'd6},   // R10
    {8'd10, 36'h2_007F_F000, 8'd6},   // R10
    {8'd10, 36'h2_0080_1000, 8'd1},   // R10 masked bound
    {8'd9,  36'hF_0000_0000, 8'd1}    // R9
  };

  task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input int idx, input logic [PA_W-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_idx = 7'(idx); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic look(input logic [PA_W-1:0] a);
    @(negedge clk);
    lk_req = 1'b1; lk_addr = a;
    @(negedge clk);
    lk_req = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(11, {7'd0, res_valid}, 8'd0);                 // R11
    look(36'h0_1000_0000);
    check(1, {7'd0, res_valid}, 8'd1);                  // R1
    check(11, res_type, 8'hFF);                         // R11
    @(negedge clk);
    check(1, {7'd0, res_valid}, 8'd0);                  // R1 one-cycle strobe
    check(1, res_type, 8'hFF);                          // R1 held

    for (int i = 0; i < 88; i++) wr(3'd0, i, PA_W'(i)); // R12
    wr(3'd1, 0, 36'h0_2000_0006); wr(3'd2, 0, 36'hF_F000_0800);
    wr(3'd1, 1, 36'h0_2800_0004); wr(3'd2, 1, 36'hF_FF00_0800);
    wr(3'd1, 2, 36'h0_4000_0006); wr(3'd2, 2, 36'hF_C000_0800);
    wr(3'd1, 3, 36'h0_4000_0000); wr(3'd2, 3, 36'hF_FFFF_F800);
    wr(3'd1, 4, 36'h0_8000_0005); wr(3'd2, 4, 36'hF_F000_0800);
    wr(3'd1, 5, 36'h0_8000_0001); wr(3'd2, 5, 36'hF_FFFF_0800);
    wr(3'd1, 6, 36'h0_C000_0006); wr(3'd2, 6, 36'hF_F000_0000);
    wr(3'd1, 7, 36'h0_0000_0006); wr(3'd2, 7, 36'hF_8000_0800);
    wr(3'd4, 0, 36'h2_0080_1234);

    wr(3'd3, 0, 36'h401);                               // R2 global off
    look(36'h0_000C_0000);
    check(2, res_type, 8'hFF);
    look(36'h1_0000_0000);
    check(2, res_type, 8'hFF);

    wr(3'd3, 0, 36'h801);                               // R6 fixed off
    look(36'h0_000C_0000);
    check(6, res_type, 8'd6);

    wr(3'd3, 0, 36'hC01);                               // R12 control write
    for (int v = 0; v < NV; v++) begin
      look(VEC[v][43:8]);
      check(int'(VEC[v][51:44]), res_type, VEC[v][7:0]);
    end

    wr(3'd0, 87, 36'h5);                                // R12 late rewrite
    look(36'h0_000F_F000);
    check(12, res_type, 8'd5);
    @(negedge clk);
    check(1, res_type, 8'd5);                           // R1 held

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule